// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits in the column path of a synchronous DRAM controller. When a READ or WRITE command is accepted, the controller gives it the starting column and the burst settings held in the mode register. From the next cycle on, the block presents one column address per clock until the burst is over. It supports fixed bursts of one, two, four or eight beats, in either a sequential (incrementing) or an interleaved (XOR) order. Each fixed burst stays inside the aligned group of columns whose size equals the burst length. It also has a continuous page mode, which walks the whole open row and wraps from the top column back to zero until something stops it.

A burst can end before its natural end in three ways. A burst-terminate pulse stops it. An interrupt pulse from another command that cuts the access short (for example a precharge) also stops it. A new READ or WRITE start may arrive on any clock, and it replaces the burst in progress at once, with no alignment to earlier beats. The block does not handle data capture, latency delay or byte masking.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is applied and in the first cycle after it, `col_valid_o` and `col_last_o` are low.
- R2: A `cmd_start_i` pulse sampled at a clock edge makes `col_valid_o` high from that edge on, and the first beat's `col_o` equals the `start_col_i` captured at that edge, in both orders.
- R3: `bl_code_i` sets the burst length: code 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives continuous page mode. Codes 4, 5 and 6 are reserved and give 1 beat.
- R4: With `interleave_i` = 0 and a fixed length L, beat k presents column base + ((s + k) mod L), where s = start mod L and base = start − s.
- R5: With `interleave_i` = 1 and a fixed length L, beat k presents column base + (s XOR k).
- R6: In page mode, beat k presents (start + k) mod 2^COL_W, so the column wraps from the top column to 0. The burst never ends by itself, and `interleave_i` has no effect.
- R7: `col_last_o` is high exactly on the final beat of a fixed-length burst, and `col_valid_o` is low on the cycle after it unless a new start was sampled. It is never high in page mode.
- R8: `burst_term_i` sampled high during a valid beat ends the burst. That beat is the last one presented, and `col_valid_o` is low on the next cycle.
- R9: `cmd_intr_i` sampled high during a valid beat ends the burst in the same way as R8.
- R10: A `cmd_start_i` during a running burst cuts it short, and beat 0 of the new burst follows on the next cycle. A start wins over a terminate or interrupt sampled at the same edge.
- R11: `burst_term_i` or `cmd_intr_i` sampled while no burst is running has no effect, and `col_valid_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_start_i | input | 1 | READ/WRITE accepted: begin a new burst |
| start_col_i | input | COL_W | Starting column of the access |
| bl_code_i | input | 3 | Burst-length code (0,1,2,3 = 1,2,4,8 beats; 7 = page; others = 1) |
| interleave_i | input | 1 | 1 = interleaved order, 0 = sequential |
| burst_term_i | input | 1 | Burst-terminate command |
| cmd_intr_i | input | 1 | Other command that interrupts the burst |
| col_o | output | COL_W | Column address of the current beat |
| col_valid_o | output | 1 | A beat is presented on `col_o` |
| col_last_o | output | 1 | Current beat is the final one of a fixed burst |

## Verification
The bench builds the block with its default COL_W of 9, so a page-mode burst covers 512 columns. With that size, a run that starts at column 510 shows the wrap to 0 within a few beats. A run of 600 beats shows that page mode never ends by itself. The width also leaves room for every fixed length, so blocks aligned on 8 columns can be placed anywhere in the row and every start offset inside them can be hit.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef logic [2:0] bl_code_t;

  localparam bl_code_t BLC_1    = 3'd0;
  localparam bl_code_t BLC_2    = 3'd1;
  localparam bl_code_t BLC_4    = 3'd2;
  localparam bl_code_t BLC_8    = 3'd3;
  localparam bl_code_t BLC_PAGE = 3'd7;

  // log2 of the fixed burst length; reserved codes collapse to one beat
  function automatic int unsigned bl_log2(input bl_code_t code);
    case (code)
      BLC_2:   return 1;
      BLC_4:   return 2;
      BLC_8:   return 3;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
  import bcg_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  bl_code_t           bl_code,
  input  logic               itlv_req,
  output logic [COL_W-1:0]   wrap_mask,
  output logic               page_mode,
  output logic               itlv_eff
);
  int unsigned span_log2;

  always_comb begin
    page_mode = (bl_code == BLC_PAGE);
    span_log2 = bl_log2(bl_code);
    // interleaved order is not defined for a whole page
    itlv_eff  = itlv_req & ~page_mode;
  end

  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign wrap_mask[i] = page_mode | (i < span_log2);
  end
endmodule

// File: rtl/bcg_beat_ctrl.sv
module bcg_beat_ctrl #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             stop_term,
  input  logic             stop_intr,
  input  logic [COL_W-1:0] go_col,
  input  logic [COL_W-1:0] go_mask,
  input  logic             go_page,
  input  logic             go_itlv,
  output logic             busy,
  output logic [COL_W-1:0] beat_cnt,
  output logic [COL_W-1:0] anchor_col,
  output logic [COL_W-1:0] span_mask,
  output logic             page_q,
  output logic             itlv_q,
  output logic             final_beat
);
  logic             busy_d;
  logic [COL_W-1:0] beat_d;
  logic             beat_en;
  logic             cfg_en;
  logic             halt;

  always_comb begin
    final_beat = busy & ~page_q & (beat_cnt == span_mask);
    halt       = busy & (stop_term | stop_intr | final_beat);
    cfg_en     = go;
    beat_en    = go | (busy & ~halt);
    busy_d     = go | (busy & ~halt);
    beat_d     = go ? '0 : beat_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else begin
      busy <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_cnt <= '0;
    end else if (beat_en) begin
      beat_cnt <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      anchor_col <= '0;
      span_mask  <= '0;
      page_q     <= 1'b0;
      itlv_q     <= 1'b0;
    end else if (cfg_en) begin
      anchor_col <= go_col;
      span_mask  <= go_mask;
      page_q     <= go_page;
      itlv_q     <= go_itlv;
    end
  end
endmodule

// File: rtl/bcg_col_map.sv
module bcg_col_map #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] anchor_col,
  input  logic [COL_W-1:0] beat_cnt,
  input  logic [COL_W-1:0] span_mask,
  input  logic             itlv,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] offset;
  logic [COL_W-1:0] seq_sum;
  logic [COL_W-1:0] xor_mix;

  always_comb begin
    offset  = anchor_col & span_mask;
    seq_sum = offset + beat_cnt;
    xor_mix = offset ^ beat_cnt;
  end

  // bits above the wrap window keep the start column; bits inside follow the order
  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col[i] = span_mask[i] ? (itlv ? xor_mix[i] : seq_sum[i]) : anchor_col[i];
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import bcg_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             interleave_i,
  input  logic             burst_term_i,
  input  logic             cmd_intr_i,
  output logic [COL_W-1:0] col_o,
  output logic             col_valid_o,
  output logic             col_last_o
);
  logic             rst_meta;
  logic             rst_sync_n;
  logic [COL_W-1:0] dec_mask;
  logic             dec_page;
  logic             dec_itlv;
  logic [COL_W-1:0] beat_w;
  logic [COL_W-1:0] anchor_w;
  logic [COL_W-1:0] mask_w;
  logic             page_w;
  logic             itlv_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  bcg_len_decode #(.COL_W(COL_W)) u_dec (
    .bl_code   (bl_code_i),
    .itlv_req  (interleave_i),
    .wrap_mask (dec_mask),
    .page_mode (dec_page),
    .itlv_eff  (dec_itlv)
  );

  bcg_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .go         (cmd_start_i),
    .stop_term  (burst_term_i),
    .stop_intr  (cmd_intr_i),
    .go_col     (start_col_i),
    .go_mask    (dec_mask),
    .go_page    (dec_page),
    .go_itlv    (dec_itlv),
    .busy       (col_valid_o),
    .beat_cnt   (beat_w),
    .anchor_col (anchor_w),
    .span_mask  (mask_w),
    .page_q     (page_w),
    .itlv_q     (itlv_w),
    .final_beat (col_last_o)
  );

  bcg_col_map #(.COL_W(COL_W)) u_map (
    .anchor_col (anchor_w),
    .beat_cnt   (beat_w),
    .span_mask  (mask_w),
    .itlv       (itlv_w),
    .col        (col_o)
  );
endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             cmd_start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             burst_term_i,
  input logic             cmd_intr_i,
  input logic [COL_W-1:0] col_o,
  input logic             col_valid_o,
  input logic             col_last_o,
  input logic             page_w,
  input logic             itlv_w,
  input logic [COL_W-1:0] mask_w,
  input logic [COL_W-1:0] anchor_w
);
  assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_start_i |=> (col_valid_o && col_o == $past(start_col_i)));

  assert_page_inc_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (col_valid_o && page_w && !cmd_start_i && !burst_term_i && !cmd_intr_i)
      |=> (col_valid_o && col_o == $past(col_o) + 1'b1));

  assert_page_no_last_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (col_valid_o && page_w) |-> !col_last_o);

  assert_last_ends_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (col_last_o && !cmd_start_i) |=> !col_valid_o);

  assert_term_stops_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (col_valid_o && burst_term_i && !cmd_start_i) |=> !col_valid_o);

  assert_intr_stops_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (col_valid_o && cmd_intr_i && !cmd_start_i) |=> !col_valid_o);

  assert_idle_stays_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!col_valid_o && !cmd_start_i) |=> !col_valid_o);

  assert_in_window_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (col_valid_o && !page_w) |-> ((col_o & ~mask_w) == (anchor_w & ~mask_w)));

  assert_page_seq_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (col_valid_o && page_w) |-> !itlv_w);
endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .cmd_start_i  (cmd_start_i),
  .start_col_i  (start_col_i),
  .burst_term_i (burst_term_i),
  .cmd_intr_i   (cmd_intr_i),
  .col_o        (col_o),
  .col_valid_o  (col_valid_o),
  .col_last_o   (col_last_o),
  .page_w       (page_w),
  .itlv_w       (itlv_w),
  .mask_w       (mask_w),
  .anchor_w     (anchor_w)
);

// File: tb/sim_sdram_burst_colgen.sv
`timescale 1ns/1ps
module sim_sdram_burst_colgen;
  localparam int COL_W = 9;
  localparam int NCOL  = 1 << COL_W;

  logic             clk;
  logic             rst_n;
  logic             cmd_start_i;
  logic [COL_W-1:0] start_col_i;
  logic [2:0]       bl_code_i;
  logic             interleave_i;
  logic             burst_term_i;
  logic             cmd_intr_i;
  logic [COL_W-1:0] col_o;
  logic             col_valid_o;
  logic             col_last_o;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;
  string tag  = "R1";

  // behavioural reference state
  bit m_act  = 0;
  int m_st   = 0;
  int m_len  = 1;
  bit m_page = 0;
  bit m_ilv  = 0;
  int m_k    = 0;

  sdram_burst_colgen #(.COL_W(COL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_start_i(cmd_start_i), .start_col_i(start_col_i),
    .bl_code_i(bl_code_i), .interleave_i(interleave_i), .burst_term_i(burst_term_i),
    .cmd_intr_i(cmd_intr_i), .col_o(col_o), .col_valid_o(col_valid_o), .col_last_o(col_last_o)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic int exp_col();
    int base, off;
    if (m_page) return (m_st + m_k) % NCOL;
    off  = m_st % m_len;
    base = m_st - off;
    if (m_ilv) return base + (off ^ m_k);
    return base + ((off + m_k) % m_len);
  endfunction

  task automatic compare();
    bit e_last;
    e_last = m_act && !m_page && (m_k == m_len - 1);
    vectors++;
    if (col_valid_o !== m_act) begin
      fails++;
      $display("FAIL %s valid actual=%0b expected=%0b", tag, col_valid_o, m_act);
    end
    if (col_last_o !== e_last) begin
      fails++;
      $display("FAIL %s last actual=%0b expected=%0b", tag, col_last_o, e_last);
    end
    if (m_act && (int'(col_o) != exp_col())) begin
      fails++;
      $display("FAIL %s col actual=%0d expected=%0d", tag, col_o, exp_col());
    end
  endtask

  function automatic int len_of(input int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 1;
    endcase
  endfunction

  // compare at the falling edge, then drive inputs for the next rising edge
  task automatic step(input bit s, input int c, input int code, input bit il,
                      input bit t, input bit k);
    @(negedge clk);
    compare();
    cmd_start_i  = s;
    start_col_i  = c[COL_W-1:0];
    bl_code_i    = code[2:0];
    interleave_i = il;
    burst_term_i = t;
    cmd_intr_i   = k;
    if (s) begin
      m_act = 1; m_k = 0; m_st = c % NCOL;
      m_page = (code == 7);
      m_len  = m_page ? NCOL : len_of(code);
      m_ilv  = il && !m_page;
    end else if (m_act && (t || k)) begin
      m_act = 0;
    end else if (m_act && !m_page && m_k == m_len - 1) begin
      m_act = 0;
    end else if (m_act) begin
      m_k = (m_k + 1) % m_len;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cmd_start_i = 0; start_col_i = '0; bl_code_i = '0;
    interleave_i = 0; burst_term_i = 0; cmd_intr_i = 0;
    // R1: outputs low in reset
    tag = "R1";
    repeat (3) begin @(negedge clk); compare(); end
    rst_n = 1;
    idle(4);

    // R2, R4: sequential 8 from mid-block offset; 4 and 2 lengths
    tag = "R2";  step(1, 37, 3, 0, 0, 0);
    tag = "R4";  idle(9);
    step(1, 6, 2, 0, 0, 0); idle(5);
    step(1, 3, 1, 0, 0, 0); idle(3);
    // R5: interleaved 8 and 4
    tag = "R5";  step(1, 45, 3, 1, 0, 0); idle(9);
    step(1, 14, 2, 1, 0, 0); idle(5);
    // R3: length 1 and reserved codes 4,5,6 give one beat
    tag = "R3";
    step(1, 100, 0, 0, 0, 0); idle(2);
    for (int c = 4; c < 7; c++) begin step(1, 200 + c, c, 1, 0, 0); idle(2); end
    // R7: back-to-back fixed bursts, start on the last beat
    tag = "R7";  step(1, 8, 1, 0, 0, 0); idle(1); step(1, 20, 2, 1, 0, 0); idle(5);
    // R6: page mode wraps 511 -> 0, interleave ignored, long run
    tag = "R6";  step(1, 510, 7, 1, 0, 0); idle(600);
    // R8: terminate a page burst and a fixed burst
    tag = "R8";  step(0, 0, 0, 0, 1, 0); idle(2);
    step(1, 64, 3, 0, 0, 0); idle(2); step(0, 0, 0, 0, 1, 0); idle(3);
    // R9: interrupt command stops a burst
    tag = "R9";  step(1, 130, 3, 1, 0, 0); idle(3); step(0, 0, 0, 0, 0, 1); idle(3);
    // R10: new start truncates, and beats a same-cycle terminate
    tag = "R10"; step(1, 50, 3, 0, 0, 0); idle(2); step(1, 300, 2, 1, 0, 0);
    idle(1); step(1, 77, 3, 0, 1, 1); idle(10);
    // R11: stop pulses while idle leave the block idle
    tag = "R11"; step(0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 0, 1); idle(3);

    // mixed traffic across all orders and lengths
    tag = "R4";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 100;
      step(r < 15, $urandom % NCOL, $urandom % 8, $urandom % 2,
           (r >= 15 && r < 19), (r >= 19 && r < 22));
    end
    idle(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule